// File: doc/BRIEF.md
# Retrying Bus Cycle Sequencer

This block sits between a processor core and a shared 32-bit bus. It accepts one access at a time from the core: read or write, address, write data, byte-lane selects and a 3-bit function code. It holds the bus cycle open until the far side acknowledges it, asks for a retry, or reports an error. Only one cycle is outstanding at any time.

When the bus asks for a retry, the sequencer drops the cycle and waits for a pseudo-random number of clocks. The wait length comes from a free-running LFSR, so requesters that collide tend to come back at different times. It then reissues the identical cycle. If a cycle receives no response within a parameterised window, the sequencer abandons it and reports a bus error to the core, so a missing target cannot hold the shared bus forever. Every failed access leaves behind a descriptor word and the failing address for the exception handler.

Completion is reported as a single-cycle `done` pulse carrying an ok/error status. Read data is valid in that same cycle.

Top module: `bus_retry_master`

## Requirements
- R1: While idle, `req_ready` is high and `bus_cyc` is low. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle `bus_cyc` is high, and `bus_addr`, `bus_we`, `bus_wdata`, `bus_sel` and `bus_fc` carry the captured request. These values stay unchanged for the whole cycle and for every replay of it.
- R2: When several responses arrive in the same active cycle, error wins over retry, and retry wins over acknowledge.
- R3: An acknowledge ends the access. In the next cycle `bus_cyc` is low, `done` is high, `done_err` is low, and `rdata` equals the `bus_rdata` value sampled together with the acknowledge.
- R4: A retry drops `bus_cyc` for exactly B cycles and then reissues the same cycle. B is the low four bits of the LFSR value in the cycle where the retry was seen, plus one, so B is always between 1 and 16.
- R5: The LFSR is 8 bits wide and reset to 8'hB5. It advances on every clock as next = {L[6:0], L[7]^L[5]^L[4]^L[3]}.
- R6: If an issue of a cycle receives no response during TIMEOUT consecutive active cycles, the access ends after that cycle with `done` and `done_err` high. The window restarts on every issue, including replays. A response in the last cycle of the window is honoured.
- R7: An error response ends the access. In the next cycle `bus_cyc` is low and `done` and `done_err` are both high.
- R8: On every failed access, `err_word` is loaded as follows: bit 0 is the write flag, bits 3:1 the function code, bits 7:4 the byte selects, bits 11:8 the active-state number (1), bit 12 is 1 for a timeout and 0 for an error response, and all other bits are zero. `err_addr` is loaded with the address. Both hold until the next failure.
- R9: `done` is high for exactly one cycle per access and at no other time. After reset, `done`, `err_word` and `err_addr` are zero and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents an access |
| req_ready | output | 1 | Sequencer idle and able to take an access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Access address |
| req_wdata | input | 32 | Write data |
| req_sel | input | 4 | Byte-lane selects |
| req_fc | input | 3 | Function code |
| done | output | 1 | Single-cycle completion pulse |
| done_err | output | 1 | Completion status, 1 = bus error |
| rdata | output | 32 | Read data, valid with `done` |
| err_word | output | 32 | Descriptor of the last failed access |
| err_addr | output | 32 | Address of the last failed access |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus write flag |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_sel | output | 4 | Bus byte-lane selects |
| bus_fc | output | 3 | Bus function code |
| bus_ack | input | 1 | Target acknowledges |
| bus_rty | input | 1 | Target asks for a retry |
| bus_err | input | 1 | Target reports an error |
| bus_rdata | input | 32 | Read data from the target |

## Verification
The bench builds the sequencer with TIMEOUT set to 12 and keeps the default LFSR seed. The short window lets the bench exercise full timeouts, an acknowledge in the last window cycle, and a replay that would have timed out had the window not restarted, all in a few hundred clocks. A long run of transactions with repeated retries walks the LFSR through many states, so backoff lengths near both ends of the 1 to 16 range occur and are predicted cycle by cycle.

// File: rtl/busm_pkg.sv
package busm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACTIVE  = 3'd1,
        ST_BACKOFF = 3'd2
    } state_e;

    // descriptor word field positions
    localparam int EW_WE_BIT   = 0;
    localparam int EW_FC_LSB   = 1;
    localparam int EW_SEL_LSB  = 4;
    localparam int EW_ST_LSB   = 8;
    localparam int EW_ST_W     = 4;
    localparam int EW_TMO_BIT  = 12;
    localparam int EW_W        = 32;

endpackage

// File: rtl/busm_lfsr.sv
module busm_lfsr #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    SEED = 8'hB5,
    parameter logic [W-1:0]    TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] lfsr_d, lfsr_q;
    logic         fb;

    always_comb begin
        fb     = ^(lfsr_q & TAPS);
        lfsr_d = {lfsr_q[W-2:0], fb};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;
endmodule

// File: rtl/busm_timer.sv
module busm_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = run ? cnt_q + 1'b1 : '0;
        expired = run && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/busm_capture.sv
module busm_capture
    import busm_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int FC_W  = 3
) (
    input  logic               we,
    input  logic [FC_W-1:0]    fc,
    input  logic [SEL_W-1:0]   sel,
    input  logic [EW_ST_W-1:0] st_code,
    input  logic               timed_out,
    output logic [EW_W-1:0]    word
);
    always_comb begin
        word = '0;
        word[EW_WE_BIT]                   = we;
        word[EW_FC_LSB  +: FC_W]          = fc;
        word[EW_SEL_LSB +: SEL_W]         = sel;
        word[EW_ST_LSB  +: EW_ST_W]       = st_code;
        word[EW_TMO_BIT]                  = timed_out;
    end
endmodule

// File: rtl/bus_retry_master.sv
module bus_retry_master
    import busm_pkg::*;
#(
    parameter int           ADDR_W    = 32,
    parameter int           DATA_W    = 32,
    parameter int           FC_W      = 3,
    parameter int           TIMEOUT   = 64,
    parameter int           LFSR_W    = 8,
    parameter logic [7:0]   LFSR_SEED = 8'hB5,
    parameter int           BOFF_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W/8-1:0]  req_sel,
    input  logic [FC_W-1:0]      req_fc,
    output logic                 done,
    output logic                 done_err,
    output logic [DATA_W-1:0]    rdata,
    output logic [EW_W-1:0]      err_word,
    output logic [ADDR_W-1:0]    err_addr,
    output logic                 bus_cyc,
    output logic                 bus_we,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W/8-1:0]  bus_sel,
    output logic [FC_W-1:0]      bus_fc,
    input  logic                 bus_ack,
    input  logic                 bus_rty,
    input  logic                 bus_err,
    input  logic [DATA_W-1:0]    bus_rdata
);
    localparam int SEL_W  = DATA_W / 8;
    localparam int BCNT_W = BOFF_BITS + 1;

    typedef struct packed {
        state_e              state;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [SEL_W-1:0]    sel;
        logic [FC_W-1:0]     fc;
        logic [BCNT_W-1:0]   boff;
        logic                done;
        logic                derr;
        logic [DATA_W-1:0]   rdata;
        logic [EW_W-1:0]     eword;
        logic [ADDR_W-1:0]   eaddr;
    } regs_t;

    regs_t r_d, r_q;

    logic [LFSR_W-1:0] lfsr_val;
    logic              tmo_hit;
    logic              cur_active;
    logic [EW_W-1:0]   word_err;
    logic [EW_W-1:0]   word_tmo;
    state_e            cur_state;

    assign cur_state  = r_q.state;
    assign cur_active = (r_q.state == ST_ACTIVE);

    busm_lfsr #(
        .W    (LFSR_W),
        .SEED (LFSR_W'(LFSR_SEED)),
        .TAPS (LFSR_W'(8'hB8))
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (lfsr_val)
    );

    busm_timer #(
        .LIMIT (TIMEOUT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cur_active),
        .expired (tmo_hit)
    );

    busm_capture #(
        .SEL_W (SEL_W),
        .FC_W  (FC_W)
    ) u_cap_err (
        .we        (r_q.we),
        .fc        (r_q.fc),
        .sel       (r_q.sel),
        .st_code   (EW_ST_W'(ST_ACTIVE)),
        .timed_out (1'b0),
        .word      (word_err)
    );

    busm_capture #(
        .SEL_W (SEL_W),
        .FC_W  (FC_W)
    ) u_cap_tmo (
        .we        (r_q.we),
        .fc        (r_q.fc),
        .sel       (r_q.sel),
        .st_code   (EW_ST_W'(ST_ACTIVE)),
        .timed_out (1'b1),
        .word      (word_tmo)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.derr = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.we    = req_we;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.sel   = req_sel;
                    r_d.fc    = req_fc;
                    r_d.state = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (bus_err) begin
                    r_d.done  = 1'b1;
                    r_d.derr  = 1'b1;
                    r_d.eword = word_err;
                    r_d.eaddr = r_q.addr;
                    r_d.state = ST_IDLE;
                end else if (bus_rty) begin
                    r_d.boff  = {1'b0, lfsr_val[BOFF_BITS-1:0]} + BCNT_W'(1);
                    r_d.state = ST_BACKOFF;
                end else if (bus_ack) begin
                    r_d.done  = 1'b1;
                    r_d.rdata = bus_rdata;
                    r_d.state = ST_IDLE;
                end else if (tmo_hit) begin
                    r_d.done  = 1'b1;
                    r_d.derr  = 1'b1;
                    r_d.eword = word_tmo;
                    r_d.eaddr = r_q.addr;
                    r_d.state = ST_IDLE;
                end
            end
            ST_BACKOFF: begin
                if (r_q.boff == BCNT_W'(1)) r_d.state = ST_ACTIVE;
                else                        r_d.boff  = r_q.boff - 1'b1;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign bus_cyc   = cur_active;
    assign bus_we    = r_q.we;
    assign bus_addr  = r_q.addr;
    assign bus_wdata = r_q.wdata;
    assign bus_sel   = r_q.sel;
    assign bus_fc    = r_q.fc;
    assign done      = r_q.done;
    assign done_err  = r_q.derr;
    assign rdata     = r_q.rdata;
    assign err_word  = r_q.eword;
    assign err_addr  = r_q.eaddr;

endmodule

// File: rtl/bus_retry_master_chk.sv
module bus_retry_master_chk
    import busm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LFSR_W  = 8,
    parameter int TIMEOUT = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cyc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              bus_rty,
    input logic              bus_err,
    input logic              done,
    input logic              done_err,
    input logic [LFSR_W-1:0] lfsr_val,
    input state_e            cur_state
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= 0;
        else if (bus_cyc) run_q <= run_q + 1;
        else              run_q <= 0;
    end

    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack && !bus_rty && !bus_err && $past(bus_cyc)) |-> $stable(bus_addr)); // R1
    AST_ERR_OVER_RTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_err && bus_rty) |=> (done && done_err)); // R2
    AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_ack && !bus_rty && !bus_err) |=> (done && !done_err && !bus_cyc)); // R3
    AST_RTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_rty && !bus_err) |=> (!bus_cyc && !done)); // R4
    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_val != '0); // R5
    AST_TMO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (run_q < TIMEOUT)); // R6
    AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_err) |=> (done && done_err)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BAD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_state inside {ST_IDLE, ST_ACTIVE, ST_BACKOFF}) |=> (cur_state == ST_IDLE)); // R1
endmodule

bind bus_retry_master bus_retry_master_chk #(
    .ADDR_W  (ADDR_W),
    .LFSR_W  (LFSR_W),
    .TIMEOUT (TIMEOUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cyc   (bus_cyc),
    .bus_addr  (bus_addr),
    .bus_ack   (bus_ack),
    .bus_rty   (bus_rty),
    .bus_err   (bus_err),
    .done      (done),
    .done_err  (done_err),
    .lfsr_val  (lfsr_val),
    .cur_state (cur_state)
);

// File: tb/bus_retry_master_bench.sv
module bus_retry_master_bench;
    localparam int TMO = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_we = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_sel = '0;
    logic [2:0]  req_fc = '0;
    logic        done, done_err;
    logic [31:0] rdata, err_word, err_addr;
    logic        bus_cyc, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_sel;
    logic [2:0]  bus_fc;
    logic        bus_ack = 1'b0, bus_rty = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    int total = 0, bad = 0, ncyc = 0;

    always #4 clk = ~clk;

    bus_retry_master #(.TIMEOUT(TMO)) u_bus_retry_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_sel(req_sel), .req_fc(req_fc),
        .done(done), .done_err(done_err), .rdata(rdata),
        .err_word(err_word), .err_addr(err_addr),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_sel(bus_sel), .bus_fc(bus_fc),
        .bus_ack(bus_ack), .bus_rty(bus_rty), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_st = 0, m_tmo = 0, m_boff = 0;
    logic [7:0]  m_lfsr = 8'hB5;
    logic        m_we = 0;
    logic [31:0] m_addr = 0, m_wdata = 0, m_rdata = 0, m_eword = 0, m_eaddr = 0;
    logic [3:0]  m_sel = 0;
    logic [2:0]  m_fc = 0;
    logic        m_done = 0, m_derr = 0;

    function automatic logic [31:0] desc(input bit tmo);
        return {19'd0, tmo, 4'd1, m_sel, m_fc, m_we};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tmo = 0; m_boff = 0; m_lfsr = 8'hB5;
            m_done = 0; m_derr = 0; m_rdata = 0; m_eword = 0; m_eaddr = 0;
            m_we = 0; m_addr = 0; m_wdata = 0; m_sel = 0; m_fc = 0;
        end else begin
            m_done = 0; m_derr = 0;
            if (m_st == 0) begin
                if (req_valid) begin
                    m_we = req_we; m_addr = req_addr; m_wdata = req_wdata;
                    m_sel = req_sel; m_fc = req_fc; m_st = 1; m_tmo = 0;
                end
            end else if (m_st == 1) begin
                if (bus_err) begin
                    m_done = 1; m_derr = 1; m_eword = desc(0); m_eaddr = m_addr; m_st = 0;
                end else if (bus_rty) begin
                    m_boff = int'(m_lfsr[3:0]) + 1; m_st = 2;
                end else if (bus_ack) begin
                    m_done = 1; m_rdata = bus_rdata; m_st = 0;
                end else if (m_tmo == TMO - 1) begin
                    m_done = 1; m_derr = 1; m_eword = desc(1); m_eaddr = m_addr; m_st = 0;
                end else begin
                    m_tmo++;
                end
            end else begin
                if (m_boff == 1) begin m_st = 1; m_tmo = 0; end
                else m_boff--;
            end
            m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(req_ready == (m_st == 0), "R1 req_ready", 32'(req_ready), 32'(m_st == 0));
            chk(bus_cyc == (m_st == 1), "R4/R5 bus_cyc", 32'(bus_cyc), 32'(m_st == 1));
            if (m_st == 1) begin
                chk(bus_addr == m_addr, "R1 bus_addr", bus_addr, m_addr);
                chk(bus_wdata == m_wdata, "R1 bus_wdata", bus_wdata, m_wdata);
                chk({bus_we, bus_fc, bus_sel} == {m_we, m_fc, m_sel}, "R1 bus_ctl",
                    32'({bus_we, bus_fc, bus_sel}), 32'({m_we, m_fc, m_sel}));
            end
            chk(done == m_done, "R9 done", 32'(done), 32'(m_done));
            chk(done_err == m_derr, "R2/R6/R7 done_err", 32'(done_err), 32'(m_derr));
            if (m_done && !m_derr) chk(rdata == m_rdata, "R3 rdata", rdata, m_rdata);
            chk(err_word == m_eword, "R8 err_word", err_word, m_eword);
            chk(err_addr == m_eaddr, "R8 err_addr", err_addr, m_eaddr);
        end
    end

    // ---------------- bus responder ----------------
    // kind: 0 ack, 1 retry, 2 error, 3 silent, 4 error+retry, 5 ack+retry
    int q_kind[$], q_dly[$];
    int r_kind = 0, r_dly = 0, r_cnt = 0, tenures = 0;
    logic prev_cyc = 1'b0;

    always @(negedge clk) begin
        bus_ack = 0; bus_rty = 0; bus_err = 0; bus_rdata = 32'hDEAD_BEEF;
        if (rst_n && bus_cyc) begin
            if (!prev_cyc) begin
                tenures++;
                r_cnt = 0;
                if (q_kind.size() > 0) begin r_kind = q_kind.pop_front(); r_dly = q_dly.pop_front(); end
                else begin r_kind = 0; r_dly = 0; end
            end else begin
                r_cnt++;
            end
            if (r_cnt == r_dly) begin
                case (r_kind)
                    0: begin bus_ack = 1; bus_rdata = bus_addr ^ 32'h5A5A_0000 ^ 32'(tenures); end
                    1: bus_rty = 1;
                    2: bus_err = 1;
                    4: begin bus_err = 1; bus_rty = 1; end
                    5: begin bus_ack = 1; bus_rty = 1; end
                    default: ;
                endcase
            end
        end
        prev_cyc = rst_n && bus_cyc;
    end

    task automatic plan(input int k, input int d);
        q_kind.push_back(k); q_dly.push_back(d);
    endtask

    task automatic run_txn(input logic we, input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] s, input logic [2:0] f,
                           input bit xerr, input bit xtmo, input int xten, input string tag);
        int guard;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_we = we; req_addr = a; req_wdata = d; req_sel = s; req_fc = f; req_valid = 1;
        tenures = 0;
        @(negedge clk);
        req_valid = 0;
        guard = 0;
        while (!done && guard < 3000) begin @(negedge clk); guard++; end
        chk(done == 1'b1, {tag, " done seen"}, 32'(done), 32'd1);
        chk(done_err == xerr, {tag, " status"}, 32'(done_err), 32'(xerr));
        chk(tenures == xten, {tag, " issue count"}, 32'(tenures), 32'(xten));
        if (xerr) begin
            chk(err_word[12] == xtmo, {tag, " R8 cause bit"}, 32'(err_word[12]), 32'(xtmo));
            chk(err_addr == a, {tag, " R8 address"}, err_addr, a);
            chk(err_word[11:0] == {4'd1, s, f, we}, {tag, " R8 fields"},
                32'(err_word[11:0]), 32'({4'd1, s, f, we}));
        end
    endtask

    always @(posedge clk) begin
        ncyc++;
        if (ncyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", ncyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R9 reset ready", 32'(req_ready), 32'd1);
        chk(done == 1'b0 && bus_cyc == 1'b0, "R9 reset done/cyc", 32'({done, bus_cyc}), 32'd0);
        chk(err_word == 0 && err_addr == 0, "R9 reset capture", err_word | err_addr, 32'd0);
        rst_n = 1;

        plan(0, 0); run_txn(0, 32'h0000_1000, 32'h0, 4'hF, 3'd5, 0, 0, 1, "R3 read");
        plan(0, 3); run_txn(1, 32'h0000_2004, 32'hCAFE_F00D, 4'h3, 3'd1, 0, 0, 1, "R3 write");
        plan(1, 0); plan(0, 1); run_txn(0, 32'h0000_3000, 0, 4'hC, 3'd2, 0, 0, 2, "R4 retry once");
        plan(1, 2); plan(1, 0); plan(1, 5); plan(0, 0);
        run_txn(1, 32'h0000_3100, 32'h1234_5678, 4'h1, 3'd6, 0, 0, 4, "R4 retry thrice");
        plan(2, 1); run_txn(0, 32'h0000_4000, 0, 4'hF, 3'd3, 1, 0, 1, "R7 error");
        plan(4, 0); run_txn(1, 32'h0000_4100, 32'h5, 4'h8, 3'd4, 1, 0, 1, "R2 error beats retry");
        plan(5, 2); plan(0, 0); run_txn(0, 32'h0000_4200, 0, 4'h6, 3'd0, 0, 0, 2, "R2 retry beats ack");
        plan(3, 0); run_txn(0, 32'h0000_5000, 0, 4'hF, 3'd7, 1, 1, 1, "R6 timeout");
        plan(0, TMO - 1); run_txn(1, 32'h0000_5100, 32'h9, 4'h2, 3'd2, 0, 0, 1, "R6 ack in last cycle");
        plan(1, TMO - 2); plan(0, TMO - 1);
        run_txn(0, 32'h0000_5200, 0, 4'h4, 3'd1, 0, 0, 2, "R6 window restarts on replay");
        plan(1, 0); plan(3, 0); run_txn(1, 32'h0000_5300, 32'h77, 4'hF, 3'd5, 1, 1, 2, "R6 replay times out");
        plan(0, 0); run_txn(0, 32'h0000_6000, 0, 4'hF, 3'd5, 0, 0, 1, "R8 capture held");

        seed = 7;
        for (int i = 0; i < 40; i++) begin
            int nr;
            seed = seed * 1103515245 + 12345;
            nr = (seed >>> 16) & 3;
            for (int j = 0; j < nr; j++) plan(1, (seed >>> (j + 4)) & 3);
            plan(0, (seed >>> 20) & 7);
            run_txn(seed[8], 32'h0001_0000 + 32'(i * 4), 32'(seed), 4'(seed >>> 9), 3'(seed >>> 13),
                    0, 0, nr + 1, "R5 backoff sweep");
        end

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule